// File: doc/BRIEF.md
# Transmit Buffer Bid Controller

This block sits between a host register port and a transmit buffer manager. Before sending a frame, the host makes a two-step bid. It first writes a transmit command word and then writes the frame length in bytes. The length write is the moment the controller judges the bid, and there are three possible outcomes:

- **Grant.** The length is valid and the buffer manager reports enough free words. The controller grants the bid at once.
- **Defer.** The length is valid but space is short. The bid waits, and the controller grants it later when space appears. At that point it raises a sticky buffer event, which can also drive an interrupt.
- **Reject.** The length is zero or longer than the maximum frame. The controller rejects the bid and raises a bid-error flag.

After a grant, the host streams the frame as 16-bit words into the data port. Each accepted word is forwarded to the buffer on a word-write output. The controller counts the words against the declared length, rounded up to whole words. When the last word arrives it signals frame completion and closes the grant. Writing a new command while a frame is partly written abandons that frame and starts a new bid.

Top module: `txbid_ctrl`

## Requirements
- R1: After reset, reads of the status, event and configuration registers return 0000h, `irq` is low, and no word is forwarded.
- R2: A length of 0 or above MAX_LEN (default 1518) sets the bid-error flag (status bit 7) and clears the ready flag (status bit 8). Data writes that follow are not forwarded.
- R3: When a valid length is written while `free_words` ≥ ceil(length/2), status reads 0100h from the next cycle on. The event register stays 0000h.
- R4: When a valid length is written while `free_words` < ceil(length/2), status reads 0000h. From the first cycle in which `free_words` reaches the needed count, the following hold:
  - status bit 8 is set;
  - event register bit 8 is set.
- R5: `irq` is high exactly while event bit 8 is set and configuration bit 8 is set. The configuration register reads back what was written.
- R6: A read of the event register (offset Ch) clears event bit 8 and drops `irq` in the next cycle.
- R7: A write to the data port (offset 0h) while status bit 8 is set produces `word_wr_valid` with that data in the next cycle. Such a write while status bit 8 is clear produces nothing.
- R8: The ceil(length/2)-th accepted word carries a one-cycle `frame_done`. Status bit 8 then clears, and later data writes are ignored.
- R9: A command write (offset 4h) clears both status flags and abandons a partly written frame. The next length write restarts the word count from zero.
- R10: The command, length and configuration registers read back at offsets 4h, 6h and Eh. Status is at Ah. Reads of unused offsets return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe (clears event on offset Ch) |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| free_words | input | FREE_W | Free buffer space in 16-bit words |
| irq | output | 1 | Buffer-ready interrupt |
| word_wr_valid | output | 1 | Forwarded data word strobe |
| word_wr_data | output | 16 | Forwarded data word |
| frame_done | output | 1 | Pulse with the final word of a frame |

## Verification
The bench sweeps every length from 1 to 40 bytes. For each length it checks that an odd length takes one extra word. It also checks that `frame_done` lands on exactly the last word; a counter off by one would end the frame early or leave the grant open. The length limits 0, 1518 and 1519, and a free count exactly equal to the need at 1518 bytes, expose a wrong comparison in either the length check or the space check. A deferred bid must raise the event only once space appears, must gate `irq` by the enable bit, and must clear on read; a design that raised the event on an immediate grant, or that failed to clear it, shows up as a wrong event read. An abort in mid-frame followed by a short new frame catches a counter that is not reset by a new bid.

// File: rtl/txbid_pkg.sv
package txbid_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_LEN  = 4'h6;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 4'hC;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'hE;

  localparam int unsigned BIT_READY = 8;
  localparam int unsigned BIT_ERR   = 7;
  localparam int unsigned BIT_EVT   = 8;
  localparam int unsigned BIT_IEN   = 8;

  typedef enum logic [1:0] {
    BID_IDLE = 2'd0,
    BID_WLEN = 2'd1,
    BID_PEND = 2'd2,
    BID_XFER = 2'd3
  } bid_state_e;
endpackage

// File: rtl/txbid_regfile.sv
module txbid_regfile
  import txbid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              bid_ready,
  input  logic              bid_err,
  input  logic              evt_set,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic [REG_W-1:0] cmd_q, cmd_d;
  logic [REG_W-1:0] len_q, len_d;
  logic [REG_W-1:0] cfg_q, cfg_d;
  logic             evt_q, evt_d;
  logic             cmd_we, len_we, cfg_we, evt_rd;

  always_comb begin
    cmd_we = wr_en && (wr_addr == ADDR_CMD);
    len_we = wr_en && (wr_addr == ADDR_LEN);
    cfg_we = wr_en && (wr_addr == ADDR_CFG);
    evt_rd = rd_en && (rd_addr == ADDR_EVT);
  end

  always_comb begin
    cmd_d = cmd_we ? wr_data : cmd_q;
    len_d = len_we ? wr_data : len_q;
    cfg_d = cfg_we ? wr_data : cfg_q;
    if (evt_set)     evt_d = 1'b1;
    else if (evt_rd) evt_d = 1'b0;
    else             evt_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      len_q <= '0;
      cfg_q <= '0;
      evt_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      len_q <= len_d;
      cfg_q <= cfg_d;
      evt_q <= evt_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CMD:  rd_data = cmd_q;
      ADDR_LEN:  rd_data = len_q;
      ADDR_CFG:  rd_data = cfg_q;
      ADDR_STAT: begin
        rd_data[BIT_READY] = bid_ready;
        rd_data[BIT_ERR]   = bid_err;
      end
      ADDR_EVT:  rd_data[BIT_EVT] = evt_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq = evt_q & cfg_q[BIT_IEN];
endmodule

// File: rtl/txbid_bid_fsm.sv
module txbid_bid_fsm
  import txbid_pkg::*;
#(
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned FREE_W  = 11,
  parameter int unsigned WORD_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              len_wr,
  input  logic [REG_W-1:0]  len_val,
  input  logic [FREE_W-1:0] free_words,
  input  logic              last_word,
  output logic              bid_ready,
  output logic              bid_err,
  output logic              evt_set,
  output logic [WORD_W-1:0] words_need
);
  localparam int unsigned CMP_W = (FREE_W > WORD_W) ? FREE_W : WORD_W;

  bid_state_e        state_q, state_d;
  logic              ready_d, err_d;
  logic [WORD_W-1:0] words_q, words_d;
  logic [REG_W:0]    len_plus;
  logic [WORD_W-1:0] words_new;
  logic              len_ok;
  logic [CMP_W-1:0]  free_ext, new_ext, held_ext;

  always_comb begin
    len_plus  = {1'b0, len_val} + {{REG_W{1'b0}}, 1'b1};
    words_new = len_plus[WORD_W:1];
    len_ok    = (len_val != '0) && (32'(len_val) <= MAX_LEN);
    free_ext  = CMP_W'(free_words);
    new_ext   = CMP_W'(words_new);
    held_ext  = CMP_W'(words_q);
  end

  always_comb begin
    state_d = state_q;
    ready_d = bid_ready;
    err_d   = bid_err;
    words_d = words_q;
    evt_set = 1'b0;
    if (cmd_wr) begin
      state_d = BID_WLEN;
      ready_d = 1'b0;
      err_d   = 1'b0;
    end else if (len_wr) begin
      if (!len_ok) begin
        state_d = BID_IDLE;
        ready_d = 1'b0;
        err_d   = 1'b1;
      end else begin
        err_d   = 1'b0;
        words_d = words_new;
        if (free_ext >= new_ext) begin
          state_d = BID_XFER;
          ready_d = 1'b1;
        end else begin
          state_d = BID_PEND;
          ready_d = 1'b0;
        end
      end
    end else begin
      case (state_q)
        BID_PEND: begin
          if (free_ext >= held_ext) begin
            state_d = BID_XFER;
            ready_d = 1'b1;
            evt_set = 1'b1;
          end
        end
        BID_XFER: begin
          if (last_word) begin
            state_d = BID_IDLE;
            ready_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= BID_IDLE;
      bid_ready <= 1'b0;
      bid_err   <= 1'b0;
      words_q   <= '0;
    end else begin
      state_q   <= state_d;
      bid_ready <= ready_d;
      bid_err   <= err_d;
      words_q   <= words_d;
    end
  end

  assign words_need = words_q;
endmodule

// File: rtl/txbid_word_ctr.sv
module txbid_word_ctr
  import txbid_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [REG_W-1:0]  data_in,
  input  logic              restart,
  input  logic              bid_ready,
  input  logic [WORD_W-1:0] words_need,
  output logic              last_word,
  output logic              word_wr_valid,
  output logic [REG_W-1:0]  word_wr_data,
  output logic              frame_done
);
  logic [WORD_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic              accept;
  logic [REG_W-1:0]  data_d;

  always_comb begin
    accept    = data_wr && bid_ready;
    cnt_inc   = cnt_q + {{(WORD_W-1){1'b0}}, 1'b1};
    last_word = accept && (cnt_inc == words_need);
    if (restart)        cnt_d = '0;
    else if (last_word) cnt_d = '0;
    else if (accept)    cnt_d = cnt_inc;
    else                cnt_d = cnt_q;
    data_d = accept ? data_in : word_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q         <= '0;
      word_wr_valid <= 1'b0;
      word_wr_data  <= '0;
      frame_done    <= 1'b0;
    end else begin
      cnt_q         <= cnt_d;
      word_wr_valid <= accept;
      word_wr_data  <= data_d;
      frame_done    <= last_word;
    end
  end
endmodule

// File: rtl/txbid_ctrl.sv
module txbid_ctrl
  import txbid_pkg::*;
#(
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned FREE_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic [15:0]       rd_data,
  input  logic [FREE_W-1:0] free_words,
  output logic              irq,
  output logic              word_wr_valid,
  output logic [15:0]       word_wr_data,
  output logic              frame_done
);
  localparam int unsigned WORD_W = $clog2((MAX_LEN + 1) / 2 + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cmd_wr, len_wr, data_wr;
  logic              bid_ready, bid_err, evt_set, last_word;
  logic [WORD_W-1:0] words_need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    cmd_wr  = wr_en && (wr_addr == ADDR_CMD);
    len_wr  = wr_en && (wr_addr == ADDR_LEN);
    data_wr = wr_en && (wr_addr == ADDR_DATA);
  end

  txbid_regfile i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .bid_ready (bid_ready),
    .bid_err   (bid_err),
    .evt_set   (evt_set),
    .rd_data   (rd_data),
    .irq       (irq)
  );

  txbid_bid_fsm #(
    .MAX_LEN (MAX_LEN),
    .FREE_W  (FREE_W),
    .WORD_W  (WORD_W)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd_wr     (cmd_wr),
    .len_wr     (len_wr),
    .len_val    (wr_data),
    .free_words (free_words),
    .last_word  (last_word),
    .bid_ready  (bid_ready),
    .bid_err    (bid_err),
    .evt_set    (evt_set),
    .words_need (words_need)
  );

  txbid_word_ctr #(
    .WORD_W (WORD_W)
  ) i_ctr (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .data_wr       (data_wr),
    .data_in       (wr_data),
    .restart       (cmd_wr | len_wr),
    .bid_ready     (bid_ready),
    .words_need    (words_need),
    .last_word     (last_word),
    .word_wr_valid (word_wr_valid),
    .word_wr_data  (word_wr_data),
    .frame_done    (frame_done)
  );
endmodule

// File: rtl/txbid_chk.sv
module txbid_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       rd_en,
  input logic [3:0] rd_addr,
  input logic       irq,
  input logic       word_wr_valid,
  input logic       frame_done,
  input logic       bid_ready,
  input logic       bid_err
);
  AST_ERR_EXCLUDES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bid_err |-> !bid_ready); // R2

  AST_WORD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr_valid |-> $past(bid_ready)); // R7

  AST_EVT_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'hC && bid_ready) |=> !irq); // R6

  AST_DONE_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> word_wr_valid); // R8

  AST_DONE_CLOSES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !bid_ready); // R8

  AST_CMD_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h4) |=> (!bid_ready && !bid_err)); // R9
endmodule

bind txbid_ctrl txbid_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .rd_en         (rd_en),
  .rd_addr       (rd_addr),
  .irq           (irq),
  .word_wr_valid (word_wr_valid),
  .frame_done    (frame_done),
  .bid_ready     (bid_ready),
  .bid_err       (bid_err)
);

// File: tb/test_txbid_ctrl.sv
`timescale 1ns/1ps
module test_txbid_ctrl;
  localparam int FREE_W = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, rd_en;
  logic [3:0]        wr_addr, rd_addr;
  logic [15:0]       wr_data, rd_data, word_wr_data;
  logic [FREE_W-1:0] free_words;
  logic              irq, word_wr_valid, frame_done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txbid_ctrl #(.MAX_LEN(1518), .FREE_W(FREE_W)) i_txbid_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .free_words(free_words), .irq(irq), .word_wr_valid(word_wr_valid),
    .word_wr_data(word_wr_data), .frame_done(frame_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #0.5 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_word(input string req, input logic [15:0] d,
                           input logic exp_v, input logic exp_done);
    host_wr(4'h0, d);
    chk(req, {31'd0, word_wr_valid}, {31'd0, exp_v});
    if (exp_v) chk(req, {16'd0, word_wr_data}, {16'd0, d});
    chk(req, {31'd0, frame_done}, {31'd0, exp_done});
  endtask

  task automatic bid(input logic [15:0] len);
    host_wr(4'h4, 16'h00C0);
    host_wr(4'h6, len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0; free_words = 11'd800;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    host_rd(4'hA, v); chk("R1 status", {16'd0, v}, 32'h0);
    host_rd(4'hC, v); chk("R1 event",  {16'd0, v}, 32'h0);
    host_rd(4'hE, v); chk("R1 config", {16'd0, v}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 word", {31'd0, word_wr_valid}, 32'h0);
    send_word("R7 no grant ignored", 16'h1111, 1'b0, 1'b0);

    // R10 readback
    host_wr(4'hE, 16'h0100);
    host_rd(4'hE, v); chk("R10 config", {16'd0, v}, 32'h0100);
    host_wr(4'hE, 16'h0000);
    bid(16'd9);
    host_rd(4'h4, v); chk("R10 command", {16'd0, v}, 32'h00C0);
    host_rd(4'h6, v); chk("R10 length",  {16'd0, v}, 32'h0009);
    host_rd(4'h2, v); chk("R10 unused",  {16'd0, v}, 32'h0);

    // R2 invalid lengths
    bid(16'd0);
    host_rd(4'hA, v); chk("R2 len0", {16'd0, v}, 32'h0080);
    send_word("R2 ignored after err", 16'h2222, 1'b0, 1'b0);
    bid(16'd1519);
    host_rd(4'hA, v); chk("R2 len1519", {16'd0, v}, 32'h0080);
    bid(16'hFFFF);
    host_rd(4'hA, v); chk("R2 lenFFFF", {16'd0, v}, 32'h0080);

    // R3 R7 R8 sweep of lengths
    for (int len = 1; len <= 40; len++) begin
      int words;
      words = (len + 1) / 2;
      bid(16'(len));
      host_rd(4'hA, v); chk("R3 granted", {16'd0, v}, 32'h0100);
      for (int k = 0; k < words; k++)
        send_word("R8 sweep word", 16'(len * 64 + k), 1'b1, k == words - 1);
      host_rd(4'hA, v); chk("R8 ready cleared", {16'd0, v}, 32'h0);
      send_word("R8 extra ignored", 16'hDEAD, 1'b0, 1'b0);
    end
    host_rd(4'hC, v); chk("R3 no event", {16'd0, v}, 32'h0);

    // R3 boundary: max length with exact free count
    free_words = 11'd759;
    bid(16'd1518);
    host_rd(4'hA, v); chk("R3 max exact", {16'd0, v}, 32'h0100);
    for (int k = 0; k < 759; k++)
      send_word("R8 max frame", 16'(k), 1'b1, k == 758);

    // R4 R5 R6 deferred with interrupt enabled
    host_wr(4'hE, 16'h0100);
    free_words = 11'd758;
    bid(16'd1518);
    host_rd(4'hA, v); chk("R4 pending", {16'd0, v}, 32'h0);
    chk("R5 no irq yet", {31'd0, irq}, 32'h0);
    @(negedge clk); free_words = 11'd759;
    @(negedge clk);
    chk("R5 irq raised", {31'd0, irq}, 32'h1);
    host_rd(4'hA, v); chk("R4 late grant", {16'd0, v}, 32'h0100);
    host_rd(4'hC, v); chk("R4 event set", {16'd0, v}, 32'h0100);
    chk("R6 irq cleared", {31'd0, irq}, 32'h0);
    host_rd(4'hC, v); chk("R6 event cleared", {16'd0, v}, 32'h0);

    // R5 deferred with interrupt disabled
    host_wr(4'hE, 16'h0000);
    free_words = 11'd4;
    bid(16'd20);
    host_rd(4'hA, v); chk("R4 pending short", {16'd0, v}, 32'h0);
    @(negedge clk); free_words = 11'd10;
    @(negedge clk);
    chk("R5 masked irq", {31'd0, irq}, 32'h0);
    host_rd(4'hC, v); chk("R5 event masked", {16'd0, v}, 32'h0100);

    // R9 abort mid frame
    for (int k = 0; k < 4; k++) send_word("R9 partial", 16'(k), 1'b1, 1'b0);
    host_wr(4'h4, 16'h00C0);
    host_rd(4'hA, v); chk("R9 abort status", {16'd0, v}, 32'h0);
    send_word("R9 ignored after abort", 16'hBEEF, 1'b0, 1'b0);
    host_wr(4'h6, 16'd5);
    send_word("R9 restart w0", 16'hA000, 1'b1, 1'b0);
    send_word("R9 restart w1", 16'hA001, 1'b1, 1'b0);
    send_word("R9 restart w2", 16'hA002, 1'b1, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule